// File: doc/BRIEF.md
# Debug Bus JTAG Transport

This block is a JTAG test access port. It gives an external debugger a path to the register bus of an on-chip debug module. It runs the standard sixteen-state TAP controller from the TMS pin and clocks everything on TCK. It has a five-bit instruction register. One instruction code selects a forty-bit bus-access data register. Every other code selects a one-bit bypass register. Scans move serially in on TDI and out on TDO, least significant bit first.

The debugger scans a forty-bit frame into the bus-access register. The frame holds a bus address, a data word and an operation code. When the TAP leaves Update-DR, a valid read or write frame becomes a single-cycle request to the debug module. The request's fields stay on the outputs until the next accepted request. At the next Capture-DR the block loads the register with the debug module's response word and a two-bit status. The following scan therefore returns the result of the previous request. A no-op frame collects that result without starting anything new.

Top module: `jtag_dbg_tap`

## Requirements
- R1: While `rstN` is low, the TAP is held in Test-Logic-Reset and the instruction register holds the bypass code 5'h1F. `reqValid` is low and `tdo` is low.
- R2: Five consecutive TCK rising edges with TMS high put the TAP in Test-Logic-Reset from any state. They also restore the bypass instruction.
- R3: Capture-IR loads 5'b00001 into the instruction shift stage, and Shift-IR shifts it out LSB first. The shifted-in code takes effect on the edge that leaves Update-IR.
- R4: Every instruction code other than 5'h11 selects a one-bit bypass register. That register captures 0, so during Shift-DR `tdo` equals the previous bit on `tdi`.
- R5: With code 5'h11 selected, the data register is 40 bits wide and shifts LSB first. Bits [1:0] are the operation, bits [33:2] the data and bits [39:34] the address.
- R6: Leaving Update-DR with operation 2'b10 (write) or 2'b01 (read) while `rspBusy` is low raises `reqValid` for exactly one TCK cycle. It also loads `reqAddr`, `reqData` and `reqOp` from the frame, and they hold until the next accepted request.
- R7: Operation 2'b00 (no-op) and the reserved code 2'b11 produce no request and leave the request fields unchanged.
- R8: If `rspBusy` is high when the TAP leaves Update-DR, the frame is dropped. No pulse is issued and the request fields stay unchanged.
- R9: Capture-DR loads `rspData` into bits [33:2] and the last accepted address into bits [39:34]. It loads a status into bits [1:0]: 2'b00 when `rspBusy` is low, 2'b11 when it is high.
- R10: A DR scan that passes through Pause-DR and Exit2-DR before Update-DR issues the same request as a direct scan.
- R11: `tdo` is driven low in every state other than Shift-IR and Shift-DR.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| reqValid | output | 1 | One-cycle request strobe to the debug module |
| reqAddr | output | 6 | Request address |
| reqData | output | 32 | Request write data |
| reqOp | output | 2 | Request operation, 2'b01 read, 2'b10 write |
| rspData | input | 32 | Response word from the debug module |
| rspBusy | input | 1 | Debug module still working on the previous request |

## Verification
The bus-access register is tried with a direct write, a read followed by a no-op collection scan, a write through the Pause-DR detour and a write issued while the debug module reports busy. Together these separate the request path from the response path, show that operation decoding gates the strobe, and show that the busy input both drops the frame and shows up in the captured status. Bypass scans with an irregular bit pattern, run both after reset and after a TMS-only reset from the middle of a scan, tell a one-bit register that captures zero apart from a wider or stale selection. An instruction scan checks the captured IR pattern and the bit order.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

  typedef enum logic [3:0] {
    TLR     = 4'd0,
    RTI     = 4'd1,
    SEL_DR  = 4'd2,
    CAP_DR  = 4'd3,
    SH_DR   = 4'd4,
    EX1_DR  = 4'd5,
    PAU_DR  = 4'd6,
    EX2_DR  = 4'd7,
    UPD_DR  = 4'd8,
    SEL_IR  = 4'd9,
    CAP_IR  = 4'd10,
    SH_IR   = 4'd11,
    EX1_IR  = 4'd12,
    PAU_IR  = 4'd13,
    EX2_IR  = 4'd14,
    UPD_IR  = 4'd15
  } tapState_t;

  // strobes from the TAP control to the data-register datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic selDmi;
  } tapStrobe_t;

endpackage

// File: rtl/jtag_dbg_ctrl.sv
module jtag_dbg_ctrl
  import jtag_dbg_pkg::*;
#(
  parameter int IR_WIDTH    = 5,
  parameter int DMI_CODE    = 5'h11,
  parameter int BYPASS_CODE = 5'h1F
) (
  input  logic       tck,
  input  logic       rstN,
  input  logic       tms,
  input  logic       tdi,
  output tapState_t  tapState,
  output tapStrobe_t strb,
  output logic       irTdo
);

  localparam logic [IR_WIDTH-1:0] IrBypass  = IR_WIDTH'(BYPASS_CODE);
  localparam logic [IR_WIDTH-1:0] IrDmi     = IR_WIDTH'(DMI_CODE);
  localparam logic [IR_WIDTH-1:0] IrCapture = IR_WIDTH'(1);

  tapState_t stateQ, stateD;
  logic [IR_WIDTH-1:0] irShift, irReg;

  always_comb begin
    unique case (stateQ)
      TLR:     stateD = tms ? TLR    : RTI;
      RTI:     stateD = tms ? SEL_DR : RTI;
      SEL_DR:  stateD = tms ? SEL_IR : CAP_DR;
      CAP_DR:  stateD = tms ? EX1_DR : SH_DR;
      SH_DR:   stateD = tms ? EX1_DR : SH_DR;
      EX1_DR:  stateD = tms ? UPD_DR : PAU_DR;
      PAU_DR:  stateD = tms ? EX2_DR : PAU_DR;
      EX2_DR:  stateD = tms ? UPD_DR : SH_DR;
      UPD_DR:  stateD = tms ? SEL_DR : RTI;
      SEL_IR:  stateD = tms ? TLR    : CAP_IR;
      CAP_IR:  stateD = tms ? EX1_IR : SH_IR;
      SH_IR:   stateD = tms ? EX1_IR : SH_IR;
      EX1_IR:  stateD = tms ? UPD_IR : PAU_IR;
      PAU_IR:  stateD = tms ? EX2_IR : PAU_IR;
      EX2_IR:  stateD = tms ? UPD_IR : SH_IR;
      UPD_IR:  stateD = tms ? SEL_DR : RTI;
      default: stateD = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) stateQ <= TLR;
    else       stateQ <= stateD;
  end

  // instruction shift stage and active instruction
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
      irReg   <= IrBypass;
    end else begin
      unique case (stateQ)
        TLR:     irReg   <= IrBypass;
        CAP_IR:  irShift <= IrCapture;
        SH_IR:   irShift <= {tdi, irShift[IR_WIDTH-1:1]};
        UPD_IR:  irReg   <= irShift;
        default: ;
      endcase
    end
  end

  assign tapState       = stateQ;
  assign irTdo          = irShift[0];
  assign strb.captureDr = (stateQ == CAP_DR);
  assign strb.shiftDr   = (stateQ == SH_DR);
  assign strb.updateDr  = (stateQ == UPD_DR);
  assign strb.selDmi    = (irReg == IrDmi);

endmodule

// File: rtl/jtag_dbg_dmi.sv
module jtag_dbg_dmi
  import jtag_dbg_pkg::*;
#(
  parameter int ADDR_WIDTH = 6,
  parameter int DATA_WIDTH = 32
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  tdi,
  input  tapStrobe_t            strb,
  input  logic [DATA_WIDTH-1:0] rspData,
  input  logic                  rspBusy,
  output logic                  reqValid,
  output logic [ADDR_WIDTH-1:0] reqAddr,
  output logic [DATA_WIDTH-1:0] reqData,
  output logic [1:0]            reqOp,
  output logic                  dpTdo
);

  localparam int FRAME_W  = ADDR_WIDTH + DATA_WIDTH + 2;
  localparam int DATA_LSB = 2;
  localparam int ADDR_LSB = DATA_WIDTH + 2;

  localparam logic [1:0] OpRead  = 2'b01;
  localparam logic [1:0] OpWrite = 2'b10;
  localparam logic [1:0] StOk    = 2'b00;
  localparam logic [1:0] StBusy  = 2'b11;

  logic [FRAME_W-1:0] frame;
  logic               bypassBit;
  logic [1:0]         frameOp;
  logic               accept;

  assign frameOp = frame[1:0];
  assign accept  = strb.updateDr && strb.selDmi && !rspBusy &&
                   (frameOp == OpRead || frameOp == OpWrite);

  // bus-access shift register
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      frame <= '0;
    end else if (strb.selDmi) begin
      if (strb.captureDr)
        frame <= {reqAddr, rspData, (rspBusy ? StBusy : StOk)};
      else if (strb.shiftDr)
        frame <= {tdi, frame[FRAME_W-1:1]};
    end
  end

  // one-bit bypass register for every other instruction
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassBit <= 1'b0;
    end else if (!strb.selDmi) begin
      if (strb.captureDr)    bypassBit <= 1'b0;
      else if (strb.shiftDr) bypassBit <= tdi;
    end
  end

  // request issue
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
      reqOp    <= '0;
    end else begin
      reqValid <= accept;
      if (accept) begin
        reqAddr <= frame[ADDR_LSB +: ADDR_WIDTH];
        reqData <= frame[DATA_LSB +: DATA_WIDTH];
        reqOp   <= frameOp;
      end
    end
  end

  assign dpTdo = strb.selDmi ? frame[0] : bypassBit;

endmodule

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap
  import jtag_dbg_pkg::*;
#(
  parameter int IR_WIDTH   = 5,
  parameter int DMI_CODE   = 5'h11,
  parameter int ADDR_WIDTH = 6,
  parameter int DATA_WIDTH = 32
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  logic                  tms,
  input  logic                  tdi,
  output logic                  tdo,
  output logic                  reqValid,
  output logic [ADDR_WIDTH-1:0] reqAddr,
  output logic [DATA_WIDTH-1:0] reqData,
  output logic [1:0]            reqOp,
  input  logic [DATA_WIDTH-1:0] rspData,
  input  logic                  rspBusy
);

  localparam int BYPASS_CODE = (1 << IR_WIDTH) - 1;

  tapState_t  tapState;
  tapStrobe_t strb;
  logic       irTdo;
  logic       dpTdo;

  jtag_dbg_ctrl #(
    .IR_WIDTH   (IR_WIDTH),
    .DMI_CODE   (DMI_CODE),
    .BYPASS_CODE(BYPASS_CODE)
  ) u_ctrl (
    .tck     (tck),
    .rstN    (rstN),
    .tms     (tms),
    .tdi     (tdi),
    .tapState(tapState),
    .strb    (strb),
    .irTdo   (irTdo)
  );

  jtag_dbg_dmi #(
    .ADDR_WIDTH(ADDR_WIDTH),
    .DATA_WIDTH(DATA_WIDTH)
  ) u_dmi (
    .tck     (tck),
    .rstN    (rstN),
    .tdi     (tdi),
    .strb    (strb),
    .rspData (rspData),
    .rspBusy (rspBusy),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .reqOp   (reqOp),
    .dpTdo   (dpTdo)
  );

  always_comb begin
    if (tapState == SH_IR)      tdo = irTdo;
    else if (tapState == SH_DR) tdo = dpTdo;
    else                        tdo = 1'b0;
  end

endmodule

// File: rtl/jtag_dbg_checker.sv
module jtag_dbg_checker
  import jtag_dbg_pkg::*;
#(
  parameter int ADDR_WIDTH = 6,
  parameter int DATA_WIDTH = 32
) (
  input logic                  tck,
  input logic                  rstN,
  input logic                  tms,
  input logic                  tdo,
  input logic                  reqValid,
  input logic [ADDR_WIDTH-1:0] reqAddr,
  input logic [DATA_WIDTH-1:0] reqData,
  input logic [1:0]            reqOp,
  input logic                  rspBusy,
  input tapState_t             tapState
);

  a_r6_single_pulse: assert property (@(posedge tck) disable iff (!rstN)
    reqValid |=> !reqValid);

  a_r6_fields_hold: assert property (@(posedge tck) disable iff (!rstN)
    !$stable({reqAddr, reqData, reqOp}) |-> reqValid);

  a_r6_from_update: assert property (@(posedge tck) disable iff (!rstN)
    reqValid |-> $past(tapState == UPD_DR));

  a_r7_op_valid: assert property (@(posedge tck) disable iff (!rstN)
    reqValid |-> (reqOp == 2'b01 || reqOp == 2'b10));

  a_r8_not_busy: assert property (@(posedge tck) disable iff (!rstN)
    reqValid |-> $past(!rspBusy));

  a_r2_tms_reset: assert property (@(posedge tck) disable iff (!rstN)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) &&
     $past(tms, 5)) |-> (tapState == TLR));

  a_r11_tdo_quiet: assert property (@(posedge tck) disable iff (!rstN)
    tdo |-> (tapState == SH_DR || tapState == SH_IR));

endmodule

bind jtag_dbg_tap jtag_dbg_checker #(
  .ADDR_WIDTH(ADDR_WIDTH),
  .DATA_WIDTH(DATA_WIDTH)
) u_chk (
  .tck     (tck),
  .rstN    (rstN),
  .tms     (tms),
  .tdo     (tdo),
  .reqValid(reqValid),
  .reqAddr (reqAddr),
  .reqData (reqData),
  .reqOp   (reqOp),
  .rspBusy (rspBusy),
  .tapState(tapState)
);

// File: tb/tb_jtag_dbg_tap.sv
`timescale 1ns/1ps
module tb_jtag_dbg_tap;

  logic        tck = 1'b0;
  logic        rstN;
  logic        tms;
  logic        tdi;
  logic        tdo;
  logic        reqValid;
  logic [5:0]  reqAddr;
  logic [31:0] reqData;
  logic [1:0]  reqOp;
  logic [31:0] rspData;
  logic        rspBusy;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 tck = ~tck;

  jtag_dbg_tap dut (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData), .reqOp(reqOp),
    .rspData(rspData), .rspBusy(rspBusy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one TCK bit: drive at the falling edge, sample tdo, then clock
  task automatic bitClk(input logic tmsV, input logic tdiV, output logic tdoV);
    tms = tmsV;
    tdi = tdiV;
    #1;
    tdoV = tdo;
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic idle(input int n);
    logic dummy;
    for (int i = 0; i < n; i++) bitClk(1'b0, 1'b0, dummy);
  endtask

  task automatic tmsReset();
    logic dummy;
    for (int i = 0; i < 5; i++) bitClk(1'b1, 1'b0, dummy);
    idle(1);
  endtask

  // from Run-Test/Idle, load an instruction; returns the captured IR bits
  task automatic writeIr(input logic [4:0] code, output logic [4:0] cap);
    logic d;
    bitClk(1'b1, 1'b0, d);
    bitClk(1'b1, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    for (int i = 0; i < 5; i++) begin
      bitClk(i == 4, code[i], d);
      cap[i] = d;
    end
    bitClk(1'b1, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
  endtask

  // from Run-Test/Idle, scan n DR bits and return to Run-Test/Idle
  task automatic scanDr(input int n, input logic [39:0] din, input bit viaPause,
                        output logic [39:0] dout);
    logic d;
    dout = '0;
    bitClk(1'b1, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    for (int i = 0; i < n; i++) begin
      bitClk(i == n - 1, din[i], d);
      dout[i] = d;
    end
    if (viaPause) begin
      bitClk(1'b0, 1'b0, d);
      bitClk(1'b0, 1'b0, d);
      bitClk(1'b1, 1'b0, d);
      bitClk(1'b1, 1'b0, d);
    end else begin
      bitClk(1'b1, 1'b0, d);
    end
    bitClk(1'b0, 1'b0, d);
  endtask

  function automatic logic [39:0] frameOf(input logic [5:0] a, input logic [31:0] dt,
                                          input logic [1:0] op);
    return {a, dt, op};
  endfunction

  task automatic testReset();
    chk("R1 reqValid", reqValid, 0);
    chk("R1 tdo", tdo, 0);
    chk("R1 reqAddr", reqAddr, 0);
  endtask

  task automatic testBypass(input string req);
    logic [39:0] o;
    logic [7:0]  pat = 8'b1011_0011;
    scanDr(8, {32'h0, pat}, 1'b0, o);
    chk({req, " bypass delay"}, o[7:0], {pat[6:0], 1'b0});
    chk({req, " no request"}, reqValid, 0);
  endtask

  task automatic testIrCapture();
    logic [4:0] cap;
    writeIr(5'h11, cap);
    chk("R3 IR capture", cap, 5'b00001);
  endtask

  task automatic testOtherCode();
    logic [4:0]  cap;
    logic [39:0] o;
    writeIr(5'h05, cap);
    scanDr(8, 40'h0F, 1'b0, o);
    chk("R4 code 05 bypass", o[7:0], 8'h1E);
    writeIr(5'h11, cap);
  endtask

  task automatic testWrite();
    logic [39:0] o;
    logic        d;
    rspBusy = 1'b0;
    scanDr(40, frameOf(6'h2A, 32'hDEAD_BEEF, 2'b10), 1'b0, o);
    chk("R6 pulse high", reqValid, 1);
    chk("R5 addr", reqAddr, 6'h2A);
    chk("R5 data", reqData, 32'hDEAD_BEEF);
    chk("R5 op", reqOp, 2'b10);
    bitClk(1'b0, 1'b0, d);
    chk("R6 pulse one cycle", reqValid, 0);
    chk("R6 addr held", reqAddr, 6'h2A);
  endtask

  task automatic testReadCollect();
    logic [39:0] o;
    logic        d;
    rspData = 32'h0;
    scanDr(40, frameOf(6'h11, 32'h0, 2'b01), 1'b0, o);
    chk("R6 read pulse", reqValid, 1);
    chk("R6 read op", reqOp, 2'b01);
    bitClk(1'b0, 1'b0, d);
    rspData = 32'h5A5A_1234;
    scanDr(40, frameOf(6'h00, 32'h0, 2'b00), 1'b0, o);
    chk("R9 read data", o[33:2], 32'h5A5A_1234);
    chk("R9 status ok", o[1:0], 2'b00);
    chk("R9 last address", o[39:34], 6'h11);
    chk("R7 noop no pulse", reqValid, 0);
    chk("R7 noop fields", reqOp, 2'b01);
    scanDr(40, frameOf(6'h3F, 32'h1111_2222, 2'b11), 1'b0, o);
    chk("R7 reserved no pulse", reqValid, 0);
    chk("R7 reserved addr", reqAddr, 6'h11);
  endtask

  task automatic testBusy();
    logic [39:0] o;
    rspBusy = 1'b1;
    scanDr(40, frameOf(6'h07, 32'h0123_4567, 2'b10), 1'b0, o);
    chk("R9 status busy", o[1:0], 2'b11);
    chk("R8 busy no pulse", reqValid, 0);
    chk("R8 busy addr kept", reqAddr, 6'h11);
    chk("R8 busy data kept", reqData, 32'h0);
    rspBusy = 1'b0;
  endtask

  task automatic testPause();
    logic [39:0] o;
    scanDr(40, frameOf(6'h15, 32'hA5C3_0F96, 2'b10), 1'b1, o);
    chk("R10 pause pulse", reqValid, 1);
    chk("R10 pause addr", reqAddr, 6'h15);
    chk("R10 pause data", reqData, 32'hA5C3_0F96);
  endtask

  task automatic testMidScanReset();
    logic d;
    bitClk(1'b1, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    bitClk(1'b0, 1'b0, d);
    bitClk(1'b0, 1'b1, d);
    tmsReset();
    chk("R11 tdo idle", tdo, 0);
    chk("R2 no request", reqValid, 0);
    testBypass("R2");
  endtask

  initial begin
    rstN = 1'b0; tms = 1'b1; tdi = 1'b0; rspData = '0; rspBusy = 1'b0;
    repeat (3) @(negedge tck);
    testReset();
    rstN = 1'b1;
    idle(1);
    testBypass("R4");
    testIrCapture();
    testOtherCode();
    testWrite();
    testReadCollect();
    testBusy();
    testPause();
    idle(2);
    testMidScanReset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule